// File: doc/BRIEF.md
# Programmable Sample-Rate Strobe Generator

This block produces a conversion strobe from a fast reference clock. The strobe is one cycle wide and repeats at a programmable audio sample rate. A phase accumulator adds the effective rate on every reference cycle. Its modulus is the reference frequency in hertz, so one count of the rate equals exactly one hertz of strobe rate. With the default 24.576 MHz reference, a rate value of 48000 yields 48000 strobes per second. Each strobe falls on the reference edge that is nearest after the ideal instant.

The rate comes from one of two sources, chosen by a mode bit in a configuration word. In direct mode the rate register is used as written, clamped to the usable band. In ratio mode a base frequency is picked from a small table and divided by an integer from 1 to 8. A ratio that does not give a whole number of hertz inside the band is refused: the previous rate stays in force and a flag is raised. A rate change never resets the accumulator phase, so the strobe train continues without a glitch. Active-low reset and active-low power-down both return everything to defaults and block writes.

Top module: `sr_strobe_gen`

## Requirements
- R1: For a constant effective rate N, every window of REF_HZ consecutive cycles contains exactly N cycles with `strobe` high, and each strobe lasts one cycle.
- R2: A write with `wr_sel`=0 loads the rate register. In direct mode, `rate_eff` shows the new rate two rising edges after the write edge, and the strobe pattern follows one edge later.
- R3: A direct write below MIN_RATE (default 4000) stores MIN_RATE, and a write above MAX_RATE (default 54000) stores MAX_RATE. `rate_eff` never leaves [MIN_RATE, MAX_RATE].
- R4: After `rst_n` goes low, `rate_eff` is DEF_RATE (default 48000), `strobe` is 0 and `cfg_invalid` is 0.
- R5: While `pwrdn_n` is low, every edge returns the registers, the effective rate and the phase to their defaults, and writes are ignored. After release, `rate_eff` is DEF_RATE.
- R6: A write with `wr_sel`=1 loads the configuration word. Bit RATE_W-1 is the mode (1 selects ratio mode), bits 6:4 are the base code and bits 3:0 are the divisor code. Its reset value selects direct mode.
- R7: In ratio mode the rate is base/(divisor code + 1). The base codes are 000=48000, 001=32000, 010=44100 and 011=29400 Hz (44100×2/3). The divisor codes are 0000..0111.
- R8: A ratio with a nonzero remainder, a result outside the band, base code 1xx or divisor code 1xxx sets `cfg_invalid` to 1 and leaves `rate_eff` unchanged. A valid ratio, or direct mode, clears the flag.
- R9: A change of rate does not clear the accumulator. The wrap that follows uses the residual phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Synchronous active-low power-down; forces defaults and blocks writes |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 = rate register, 1 = configuration word |
| wr_data | input | RATE_W | Write data |
| strobe | output | 1 | One-cycle conversion strobe |
| rate_eff | output | RATE_W | Rate in hertz currently driving the accumulator |
| cfg_invalid | output | 1 | Ratio-mode configuration refused |

## Verification
The accumulator runs with a reduced reference of 64000 so that strobes can be counted over whole modulus windows. A direct rate of 44100 checks that the count is exact with a non-trivial residue pattern, and a ratio of 32000/4 checks that the table path gives the same exactness. Writes are made at each clamp boundary and just past it, which separates a correct clamp from an off-by-one error. Ratio words with a remainder, with an out-of-band result, and with reserved codes separate the refusal logic from plain table lookup. A rate change in mid-phase and a power-down with a pending write are compared cycle by cycle against a behavioural model. This catches any reset of the phase or any write that leaks through.

// File: rtl/sr_pkg.sv
package sr_pkg;
   localparam int BASE_CODE_W = 3;
   localparam int DIV_CODE_W  = 4;
   localparam int NUM_BASE    = 4;
   localparam int NUM_DIV     = 8;
   localparam int BASE_LSB    = 4;
   localparam int DIV_LSB     = 0;

   // base frequency in hertz for each legal base code
   function automatic int base_hz(input int code);
      case (code)
         0:       return 48000;
         1:       return 32000;
         2:       return 44100;
         3:       return 29400;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/sr_cfg_regs.sv
module sr_cfg_regs #(
   parameter int RATE_W   = 16,
   parameter int MIN_RATE = 4000,
   parameter int MAX_RATE = 54000,
   parameter int DEF_RATE = 48000
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                pwrdn_n,
   input  logic                                wr_en,
   input  logic                                wr_sel,
   input  logic [RATE_W-1:0]                   wr_data,
   output logic [RATE_W-1:0]                   rate_q,
   output logic                                mode_q,
   output logic [sr_pkg::BASE_CODE_W-1:0]      base_q,
   output logic [sr_pkg::DIV_CODE_W-1:0]       div_q
);
   localparam logic [RATE_W-1:0] MIN_V = RATE_W'(MIN_RATE);
   localparam logic [RATE_W-1:0] MAX_V = RATE_W'(MAX_RATE);
   localparam logic [RATE_W-1:0] DEF_V = RATE_W'(DEF_RATE);

   logic [RATE_W-1:0] clamped;

   always_comb begin
      if (wr_data < MIN_V)      clamped = MIN_V;
      else if (wr_data > MAX_V) clamped = MAX_V;
      else                      clamped = wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q <= DEF_V;
         mode_q <= 1'b0;
         base_q <= '0;
         div_q  <= '0;
      end else if (!pwrdn_n) begin
         rate_q <= DEF_V;
         mode_q <= 1'b0;
         base_q <= '0;
         div_q  <= '0;
      end else if (wr_en) begin
         if (!wr_sel) begin
            rate_q <= clamped;
         end else begin
            mode_q <= wr_data[RATE_W-1];
            base_q <= wr_data[sr_pkg::BASE_LSB +: sr_pkg::BASE_CODE_W];
            div_q  <= wr_data[sr_pkg::DIV_LSB  +: sr_pkg::DIV_CODE_W];
         end
      end
   end
endmodule

// File: rtl/sr_ratio_lut.sv
module sr_ratio_lut #(
   parameter int RATE_W   = 16,
   parameter int MIN_RATE = 4000,
   parameter int MAX_RATE = 54000
) (
   input  logic [sr_pkg::BASE_CODE_W-1:0] base_code,
   input  logic [sr_pkg::DIV_CODE_W-1:0]  div_code,
   output logic [RATE_W-1:0]              ratio_hz,
   output logic                           ratio_ok
);
   localparam int ENTRIES = sr_pkg::NUM_BASE * sr_pkg::NUM_DIV;
   localparam int IDX_W   = $clog2(ENTRIES);

   logic [RATE_W-1:0] tab_hz [ENTRIES];
   logic              tab_ok [ENTRIES];
   logic [IDX_W-1:0]  idx;
   logic              reserved;

   for (genvar b = 0; b < sr_pkg::NUM_BASE; b++) begin : g_base
      for (genvar d = 0; d < sr_pkg::NUM_DIV; d++) begin : g_div
         localparam int BH  = sr_pkg::base_hz(b);
         localparam int DV  = d + 1;
         localparam int QH  = BH / DV;
         localparam bit OKC = ((BH % DV) == 0) && (QH >= MIN_RATE) && (QH <= MAX_RATE);
         assign tab_hz[b*sr_pkg::NUM_DIV + d] = RATE_W'(QH);
         assign tab_ok[b*sr_pkg::NUM_DIV + d] = OKC;
      end
   end

   assign reserved = base_code[sr_pkg::BASE_CODE_W-1] | div_code[sr_pkg::DIV_CODE_W-1];
   assign idx      = {base_code[sr_pkg::BASE_CODE_W-2:0], div_code[sr_pkg::DIV_CODE_W-2:0]};
   assign ratio_hz = tab_hz[idx];
   assign ratio_ok = !reserved && tab_ok[idx];
endmodule

// File: rtl/sr_phase_acc.sv
module sr_phase_acc #(
   parameter int REF_HZ = 24576000,
   parameter int RATE_W = 16,
   parameter int ACC_W  = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [RATE_W-1:0] step,
   output logic [ACC_W-1:0]  acc_q,
   output logic              strobe_q
);
   localparam bit POW2 = ((REF_HZ & (REF_HZ - 1)) == 0);
   localparam int SUM_W = ACC_W + 1;

   logic [SUM_W-1:0] sum;
   logic [ACC_W-1:0] acc_d;
   logic             wrap;

   assign sum = SUM_W'(acc_q) + SUM_W'(step);

   if (POW2) begin : g_natural_wrap
      assign wrap  = sum[ACC_W];
      assign acc_d = sum[ACC_W-1:0];
   end else begin : g_modulo_wrap
      localparam logic [SUM_W-1:0] MODV = SUM_W'(REF_HZ);
      logic [SUM_W-1:0] diff;
      assign diff  = sum - MODV;
      assign wrap  = (sum >= MODV);
      assign acc_d = wrap ? diff[ACC_W-1:0] : sum[ACC_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         strobe_q <= 1'b0;
      end else if (clr) begin
         acc_q    <= '0;
         strobe_q <= 1'b0;
      end else begin
         acc_q    <= acc_d;
         strobe_q <= wrap;
      end
   end
endmodule

// File: rtl/sr_strobe_gen.sv
module sr_strobe_gen #(
   parameter int REF_HZ   = 24576000,
   parameter int RATE_W   = 16,
   parameter int MIN_RATE = 4000,
   parameter int MAX_RATE = 54000,
   parameter int DEF_RATE = 48000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwrdn_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [RATE_W-1:0] wr_data,
   output logic              strobe,
   output logic [RATE_W-1:0] rate_eff,
   output logic              cfg_invalid
);
   localparam int ACC_W = $clog2(REF_HZ);
   localparam logic [RATE_W-1:0] DEF_V = RATE_W'(DEF_RATE);

   if (RATE_W < 8) begin : g_chk_w
      $error("RATE_W must hold the configuration fields");
   end
   if (MIN_RATE < 1 || MIN_RATE > DEF_RATE || DEF_RATE > MAX_RATE) begin : g_chk_band
      $error("rate band must satisfy 1 <= MIN <= DEF <= MAX");
   end
   if (MAX_RATE >= REF_HZ || MAX_RATE >= (1 << RATE_W)) begin : g_chk_max
      $error("MAX_RATE must be below REF_HZ and fit RATE_W");
   end

   logic [RATE_W-1:0]              rate_q;
   logic                           mode_q;
   logic [sr_pkg::BASE_CODE_W-1:0] base_q;
   logic [sr_pkg::DIV_CODE_W-1:0]  div_q;
   logic [RATE_W-1:0]              ratio_hz;
   logic                           ratio_ok;
   logic [RATE_W-1:0]              eff_q;
   logic                           inv_q;
   logic [ACC_W-1:0]               acc_q;
   logic                           strobe_q;

   sr_cfg_regs #(
      .RATE_W(RATE_W), .MIN_RATE(MIN_RATE), .MAX_RATE(MAX_RATE), .DEF_RATE(DEF_RATE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rate_q(rate_q), .mode_q(mode_q), .base_q(base_q), .div_q(div_q)
   );

   sr_ratio_lut #(
      .RATE_W(RATE_W), .MIN_RATE(MIN_RATE), .MAX_RATE(MAX_RATE)
   ) u_lut (
      .base_code(base_q), .div_code(div_q), .ratio_hz(ratio_hz), .ratio_ok(ratio_ok)
   );

   // effective-rate selection: a refused ratio keeps the last good rate
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eff_q <= DEF_V;
         inv_q <= 1'b0;
      end else if (!pwrdn_n) begin
         eff_q <= DEF_V;
         inv_q <= 1'b0;
      end else if (!mode_q) begin
         eff_q <= rate_q;
         inv_q <= 1'b0;
      end else if (ratio_ok) begin
         eff_q <= ratio_hz;
         inv_q <= 1'b0;
      end else begin
         inv_q <= 1'b1;
      end
   end

   sr_phase_acc #(
      .REF_HZ(REF_HZ), .RATE_W(RATE_W), .ACC_W(ACC_W)
   ) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(!pwrdn_n), .step(eff_q),
      .acc_q(acc_q), .strobe_q(strobe_q)
   );

   assign strobe      = strobe_q;
   assign rate_eff    = eff_q;
   assign cfg_invalid = inv_q;
endmodule

// File: rtl/sr_strobe_gen_chk.sv
module sr_strobe_gen_chk #(
   parameter int REF_HZ   = 24576000,
   parameter int RATE_W   = 16,
   parameter int MIN_RATE = 4000,
   parameter int MAX_RATE = 54000,
   parameter int DEF_RATE = 48000,
   parameter int ACC_W    = 25
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pwrdn_n,
   input logic              strobe,
   input logic [RATE_W-1:0] rate_eff,
   input logic              cfg_invalid,
   input logic [ACC_W-1:0]  acc_q
);
   AST_EFF_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_eff >= RATE_W'(MIN_RATE)) && (rate_eff <= RATE_W'(MAX_RATE))); // R3

   AST_PWRDN_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      !pwrdn_n |=> (rate_eff == RATE_W'(DEF_RATE)) && !strobe && !cfg_invalid && (acc_q == '0)); // R5

   AST_REFUSED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_invalid |-> $stable(rate_eff)); // R8

   AST_WRAP_RESIDUE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> (ACC_W'(acc_q) < ACC_W'($past(rate_eff)))); // R1

   AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_q < ACC_W'(REF_HZ))); // R9
endmodule

bind sr_strobe_gen sr_strobe_gen_chk #(
   .REF_HZ(REF_HZ), .RATE_W(RATE_W), .MIN_RATE(MIN_RATE),
   .MAX_RATE(MAX_RATE), .DEF_RATE(DEF_RATE), .ACC_W(ACC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .strobe(strobe),
   .rate_eff(rate_eff), .cfg_invalid(cfg_invalid), .acc_q(acc_q)
);

// File: tb/sr_strobe_gen_tb.sv
module sr_strobe_gen_tb;
   localparam int REF    = 64000;
   localparam int RW     = 16;
   localparam int MINR   = 4000;
   localparam int MAXR   = 54000;
   localparam int DEFR   = 48000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pwrdn_n = 1'b1;
   logic          wr_en = 1'b0;
   logic          wr_sel = 1'b0;
   logic [RW-1:0] wr_data = '0;
   logic          strobe;
   logic [RW-1:0] rate_eff;
   logic          cfg_invalid;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   bit cmp_on = 0;

   // behavioural reference state
   int m_rate = DEFR, m_base = 0, m_div = 0, m_eff = DEFR, m_acc = 0;
   bit m_mode = 0, m_inv = 0, m_stb = 0;

   always #2 clk = ~clk;

   sr_strobe_gen #(.REF_HZ(REF), .RATE_W(RW), .MIN_RATE(MINR), .MAX_RATE(MAXR), .DEF_RATE(DEFR))
   u_dut (.clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .wr_en(wr_en), .wr_sel(wr_sel),
          .wr_data(wr_data), .strobe(strobe), .rate_eff(rate_eff), .cfg_invalid(cfg_invalid));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic int base_of(input int code);
      if (code == 0) return 48000;
      if (code == 1) return 32000;
      if (code == 2) return 44100;
      if (code == 3) return 44100 * 2 / 3;
      return -1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n || !pwrdn_n) begin
         m_rate = DEFR; m_mode = 0; m_base = 0; m_div = 0;
         m_eff = DEFR; m_inv = 0; m_acc = 0; m_stb = 0;
      end else begin
         int b, d;
         m_stb = (m_acc + m_eff >= REF);
         m_acc = m_acc + m_eff - (m_stb ? REF : 0);
         if (!m_mode) begin
            m_eff = m_rate; m_inv = 0;
         end else begin
            b = base_of(m_base);
            d = m_div + 1;
            if (b > 0 && m_div < 8 && (b % d) == 0 && b / d >= MINR && b / d <= MAXR) begin
               m_eff = b / d; m_inv = 0;
            end else m_inv = 1;
         end
         if (wr_en) begin
            if (!wr_sel) m_rate = (wr_data < MINR) ? MINR : (wr_data > MAXR) ? MAXR : int'(wr_data);
            else begin
               m_mode = wr_data[RW-1]; m_base = int'(wr_data[6:4]); m_div = int'(wr_data[3:0]);
            end
         end
      end
      #1;
      if (cmp_on) begin
         check(strobe == m_stb, "R1 R9 strobe vs model", strobe, m_stb);
         check(rate_eff == m_eff, "R2 R7 rate_eff vs model", rate_eff, m_eff);
         check(cfg_invalid == m_inv, "R8 cfg_invalid vs model", cfg_invalid, m_inv);
      end
   end

   task automatic wr(input bit sel, input int data);
      @(negedge clk);
      wr_en = 1; wr_sel = sel; wr_data = RW'(data);
      @(negedge clk);
      wr_en = 0;
   endtask

   function automatic int cfgw(input int b, input int d);
      return 32'h8000 | (b << 4) | d;
   endfunction

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic count_window(input int exp, input string tag);
      int n = 0;
      for (int i = 0; i < REF; i++) begin
         @(negedge clk);
         if (strobe) n++;
      end
      check(n == exp, tag, n, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R4 reset state
      check(rate_eff == DEFR, "R4 reset rate", rate_eff, DEFR);
      check(strobe == 0, "R4 reset strobe", strobe, 0);
      check(cfg_invalid == 0, "R4 reset invalid", cfg_invalid, 0);
      rst_n = 1;
      cmp_on = 1;
      repeat (5) @(negedge clk);

      // R2 direct write, then exact count over a modulus window (R1)
      wr(0, 44100);
      settle();
      check(rate_eff == 44100, "R2 direct rate", rate_eff, 44100);
      count_window(44100, "R1 window count 44100");

      // R3 clamp boundaries
      wr(0, 100);   settle(); check(rate_eff == MINR, "R3 clamp low", rate_eff, MINR);
      wr(0, 3999);  settle(); check(rate_eff == MINR, "R3 clamp 3999", rate_eff, MINR);
      wr(0, 54000); settle(); check(rate_eff == MAXR, "R3 upper edge", rate_eff, MAXR);
      wr(0, 54001); settle(); check(rate_eff == MAXR, "R3 clamp 54001", rate_eff, MAXR);
      wr(0, 16'hFFFF); settle(); check(rate_eff == MAXR, "R3 clamp max", rate_eff, MAXR);
      wr(0, 4000);  settle(); check(rate_eff == MINR, "R3 lower edge", rate_eff, MINR);

      // R6 R7 ratio mode
      wr(1, cfgw(0, 1)); settle();
      check(rate_eff == 24000, "R6 R7 48000/2", rate_eff, 24000);
      wr(1, cfgw(3, 6)); settle();
      check(rate_eff == 4200, "R7 29400/7", rate_eff, 4200);
      wr(1, cfgw(2, 6)); settle();
      check(rate_eff == 6300, "R7 44100/7", rate_eff, 6300);

      // R8 refusals keep the previous rate
      wr(1, cfgw(1, 2)); settle();
      check(cfg_invalid == 1, "R8 32000/3 flag", cfg_invalid, 1);
      check(rate_eff == 6300, "R8 32000/3 hold", rate_eff, 6300);
      wr(1, cfgw(2, 7)); settle();
      check(cfg_invalid == 1 && rate_eff == 6300, "R8 44100/8", rate_eff, 6300);
      wr(1, cfgw(3, 7)); settle();
      check(cfg_invalid == 1 && rate_eff == 6300, "R8 29400/8 below band", rate_eff, 6300);
      wr(1, cfgw(4, 0)); settle();
      check(cfg_invalid == 1 && rate_eff == 6300, "R8 base code 100", rate_eff, 6300);
      wr(1, cfgw(0, 8)); settle();
      check(cfg_invalid == 1 && rate_eff == 6300, "R8 div code 1000", rate_eff, 6300);

      // R7 window in ratio mode: 32000/4
      wr(1, cfgw(1, 3)); settle();
      check(cfg_invalid == 0, "R8 flag cleared", cfg_invalid, 0);
      check(rate_eff == 8000, "R7 32000/4", rate_eff, 8000);
      count_window(8000, "R1 R7 window count 8000");

      // R6 back to direct mode uses the rate register
      wr(1, 0); settle();
      check(rate_eff == MINR, "R6 direct again", rate_eff, MINR);

      // R9 mid-phase changes, checked against the model each cycle
      wr(0, 50000); repeat (7) @(negedge clk);
      wr(0, 13000); repeat (11) @(negedge clk);
      wr(0, 31999); repeat (20) @(negedge clk);

      // R5 power-down blocks writes and restores defaults
      @(negedge clk); pwrdn_n = 0;
      wr(0, 9000);
      wr(1, cfgw(1, 0));
      @(negedge clk);
      check(rate_eff == DEFR, "R5 pwrdn rate", rate_eff, DEFR);
      check(strobe == 0, "R5 pwrdn strobe", strobe, 0);
      pwrdn_n = 1;
      settle();
      check(rate_eff == DEFR, "R5 write ignored", rate_eff, DEFR);
      check(cfg_invalid == 0, "R5 invalid clear", cfg_invalid, 0);
      repeat (10) @(negedge clk);

      cmp_on = 0;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule